// File: doc/BRIEF.md
# Serial Flash Configuration Reader

This block fetches a configuration bitstream from an external serial flash after power-up or on request. A one-cycle start request selects the flash with an active-low chip select. The block then generates its own serial clock by dividing the system clock. On a serial output line it sends a read opcode followed by a start address. After that it clocks in a fixed number of data bits and hands them to the core as bytes, each with a single-cycle valid strobe.

Every interface pin comes with its own output enable, so the pad logic can tri-state it. The done line is open-drain. While a read is in progress the block pulls it low, and it lets go once the last configuration bit has been captured. At that same point it deselects the flash, turns off all output enables and parks the serial clock low. Outgoing bits change only on falling serial-clock edges. Each incoming bit is sampled on the falling edge that follows the one on which the flash launched it.

Top module: `cfg_serial_master`

## Requirements
- R1: While reset is high, and whenever no read is in progress: `flash_cs_n_o` is 1, every output enable is 0, `done_pull_low_o` is 0, `flash_sclk_o` is 0 and `data_valid_o` is 0.
- R2: A `start_i` pulse seen while idle selects the flash one cycle later. In that cycle `flash_cs_n_o`=0, all three output enables are 1, `done_pull_low_o`=1 and `flash_sclk_o`=0.
- R3: While selected, the serial clock first rises CLK_DIV/2 system cycles after selection. It then has a period of exactly CLK_DIV system cycles, with equal high and low phases.
- R4: While the flash stays selected, `flash_mosi_o` changes only in a cycle in which `flash_sclk_o` has just fallen.
- R5: The first 32 bits presented at the rising serial-clock edges are the read opcode 0x03 and then a 24-bit address of zero, both most-significant bit first.
- R6: The flash launches data bit k on falling edge number 32+k. The block samples that bit on falling edge number 33+k, counting from 1 after selection.
- R7: Each run of 8 received bits comes out on `data_byte_o` with the first-received bit in bit 7. It is marked by `data_valid_o` high for exactly one cycle, and a read yields CFG_BITS/8 bytes.
- R8: On falling edge number 32+CFG_BITS the block deselects the flash, drops all output enables and releases `done_pull_low_o`. The serial clock stays low afterwards, and the last byte's valid pulse appears in that same cycle.
- R9: A `start_i` pulse during a read has no effect. The read keeps its opcode, edge count and byte count.
- R10: Asserting reset in the middle of a read returns the block to the idle state of R1 in the next cycle. A fresh start afterwards performs a complete, correct read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a configuration read |
| flash_miso_i | input | 1 | Serial data returned by the flash |
| flash_sclk_o | output | 1 | Generated serial clock |
| flash_sclk_oe_o | output | 1 | Output enable for the serial clock pin |
| flash_mosi_o | output | 1 | Serial command/address line to the flash |
| flash_mosi_oe_o | output | 1 | Output enable for the command line |
| flash_cs_n_o | output | 1 | Active-low flash select |
| flash_cs_oe_o | output | 1 | Output enable for the select pin |
| done_pull_low_o | output | 1 | Drives the open-drain done line low when 1 |
| data_byte_o | output | 8 | Assembled configuration byte |
| data_valid_o | output | 1 | One-cycle strobe qualifying `data_byte_o` |

## Verification
The checker assumes that `start_i` is a clean synchronous level sampled only at clock edges. It also assumes the flash holds `flash_miso_i` steady from one falling serial edge to the next, so every capture sees a settled bit. The bench's flash model respects this by changing its data line only right after it observes a falling serial clock, half a system cycle away from any capture edge. The bench drives the start pulses and reset away from the active edge, with CLK_DIV even, as the clock divider requires.

// File: rtl/cfg_sm_pkg.sv
package cfg_sm_pkg;

    localparam int          CMD_BITS   = 32;
    localparam logic [7:0]  READ_OP    = 8'h03;
    localparam logic [23:0] START_ADDR = 24'h00_0000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } rx_byte_t;

    function automatic logic [CMD_BITS-1:0] cmd_word();
        return {READ_OP, START_ADDR};
    endfunction

endpackage

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] ph_cnt;
    logic          ph_last;

    assign ph_last   = en && (ph_cnt == CW'(HALF - 1));
    assign fall_tick = ph_last && sclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (ph_last) begin
            ph_cnt <= '0;
            sclk   <= ~sclk;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_cmd_shifter.sv
module cfg_cmd_shifter
    import cfg_sm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic shift,
    output logic bit_o
);
    logic [CMD_BITS-1:0] sr;

    assign bit_o = sr[CMD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= cmd_word();
        end else if (shift) begin
            sr <= {sr[CMD_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/cfg_rx_deser.sv
module cfg_rx_deser
    import cfg_sm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     sample,
    input  logic     bit_i,
    output rx_byte_t out_o
);
    logic [6:0] acc;
    logic [2:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            bit_cnt   <= '0;
            out_o     <= '0;
        end else begin
            out_o.valid <= 1'b0;
            if (clr) begin
                bit_cnt <= '0;
            end else if (sample) begin
                acc     <= {acc[5:0], bit_i};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    out_o.data  <= {acc, bit_i};
                    out_o.valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfg_sm_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int CFG_BITS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       flash_miso_i,
    output logic       flash_sclk_o,
    output logic       flash_sclk_oe_o,
    output logic       flash_mosi_o,
    output logic       flash_mosi_oe_o,
    output logic       flash_cs_n_o,
    output logic       flash_cs_oe_o,
    output logic       done_pull_low_o,
    output logic [7:0] data_byte_o,
    output logic       data_valid_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int TOTAL = CMD_BITS + CFG_BITS;
    localparam int FW    = $clog2(TOTAL + 1);

    xfer_state_e state;
    logic [FW-1:0] fall_cnt;
    logic          busy, fall_tick, accept, cmd_bit, sclk_i;
    logic          do_shift, do_sample;
    rx_byte_t      rx;

    assign busy      = (state == ST_XFER);
    assign accept    = (state == ST_IDLE) && start_i;
    assign do_shift  = busy && fall_tick && (fall_cnt < FW'(CMD_BITS - 1));
    assign do_sample = busy && fall_tick && (fall_cnt >= FW'(CMD_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fall_cnt <= '0;
        end else if (accept) begin
            state    <= ST_XFER;
            fall_cnt <= '0;
        end else if (busy && fall_tick) begin
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == FW'(TOTAL - 1)) begin
                state <= ST_IDLE;
            end
        end
    end

    cfg_sclk_gen #(.HALF(HALF)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .en        (busy),
        .sclk      (sclk_i),
        .fall_tick (fall_tick)
    );

    cfg_cmd_shifter u_cmd (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (do_shift),
        .bit_o (cmd_bit)
    );

    cfg_rx_deser u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .sample (do_sample),
        .bit_i  (flash_miso_i),
        .out_o  (rx)
    );

    assign flash_sclk_o    = sclk_i;
    assign flash_sclk_oe_o = busy;
    assign flash_mosi_o    = busy & cmd_bit;
    assign flash_mosi_oe_o = busy;
    assign flash_cs_n_o    = ~busy;
    assign flash_cs_oe_o   = busy;
    assign done_pull_low_o = busy;
    assign data_byte_o     = rx.data;
    assign data_valid_o    = rx.valid;
endmodule

// File: rtl/cfg_serial_master_chk.sv
module cfg_serial_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       flash_miso_i,
    input logic       flash_sclk_o,
    input logic       flash_sclk_oe_o,
    input logic       flash_mosi_o,
    input logic       flash_mosi_oe_o,
    input logic       flash_cs_n_o,
    input logic       flash_cs_oe_o,
    input logic       done_pull_low_o,
    input logic [7:0] data_byte_o,
    input logic       data_valid_o
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        flash_cs_n_o |-> !flash_sclk_oe_o && !flash_mosi_oe_o && !flash_cs_oe_o); // R1

    AST_START_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (flash_cs_n_o && start_i) |=> !flash_cs_n_o); // R2

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        flash_cs_n_o |-> !flash_sclk_o); // R3

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!flash_cs_n_o && $past(!flash_cs_n_o) && !$fell(flash_sclk_o)) |-> $stable(flash_mosi_o)); // R4

    AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        data_valid_o |-> $fell(flash_sclk_o)); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        data_valid_o |=> !data_valid_o); // R7

    AST_DONE_TRACKS_SEL: assert property (@(posedge clk) disable iff (rst)
        done_pull_low_o == !flash_cs_n_o); // R8

    AST_BYTE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        data_valid_o |-> !$isunknown(data_byte_o)); // R7

    logic unused_ok;
    assign unused_ok = flash_miso_i;
endmodule

bind cfg_serial_master cfg_serial_master_chk u_chk (.*);

// File: tb/cfg_serial_master_bench.sv
module cfg_serial_master_bench;
    localparam int CLK_DIV  = 4;
    localparam int CFG_BITS = 32;
    localparam int NBYTES   = CFG_BITS / 8;
    localparam int NPAT     = 4;
    localparam logic [31:0] PATS [NPAT] = '{
        32'hA5C3_0F81, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_80FE
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic flash_miso_i = 1'b0;
    logic flash_sclk_o, flash_sclk_oe_o, flash_mosi_o, flash_mosi_oe_o;
    logic flash_cs_n_o, flash_cs_oe_o, done_pull_low_o, data_valid_o;
    logic [7:0] data_byte_o;

    always #4 clk = ~clk;

    cfg_serial_master #(.CLK_DIV(CLK_DIV), .CFG_BITS(CFG_BITS)) u_cfg_serial_master (
        .clk(clk), .rst(rst), .start_i(start_i), .flash_miso_i(flash_miso_i),
        .flash_sclk_o(flash_sclk_o), .flash_sclk_oe_o(flash_sclk_oe_o),
        .flash_mosi_o(flash_mosi_o), .flash_mosi_oe_o(flash_mosi_oe_o),
        .flash_cs_n_o(flash_cs_n_o), .flash_cs_oe_o(flash_cs_oe_o),
        .done_pull_low_o(done_pull_low_o), .data_byte_o(data_byte_o),
        .data_valid_o(data_valid_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model and monitor, evaluated away from the active edge
    logic [CFG_BITS-1:0] flash_img = '0;
    logic [31:0] cmd_cap;
    int  rises, falls, didx, nbytes, cyc, last_rise, first_rise, gap_err, mosi_err;
    logic [7:0] got [NBYTES];
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    int  valid_at_release;

    always @(negedge clk) begin
        if (prev_cs && !flash_cs_n_o) begin
            rises = 0; falls = 0; didx = 0; nbytes = 0; cyc = 0;
            last_rise = 0; first_rise = -1; gap_err = 0; mosi_err = 0;
            cmd_cap = '0; valid_at_release = 0;
        end else if (!flash_cs_n_o) begin
            cyc++;
        end
        if (!flash_cs_n_o && !prev_cs && !(prev_sclk && !flash_sclk_o) && flash_mosi_o != prev_mosi)
            mosi_err++;
        if (flash_sclk_o && !prev_sclk) begin
            if (rises < 32) cmd_cap = {cmd_cap[30:0], flash_mosi_o};
            if (rises == 0) first_rise = cyc;
            else if (cyc - last_rise != CLK_DIV) gap_err++;
            last_rise = cyc;
            rises++;
        end
        if (!flash_sclk_o && prev_sclk) begin
            falls++;
            if (falls >= 32 && didx < CFG_BITS) begin
                flash_miso_i = flash_img[CFG_BITS-1-didx];
                didx++;
            end
            if (flash_cs_n_o && data_valid_o) valid_at_release = 1;
        end
        if (data_valid_o) begin
            if (nbytes < NBYTES) got[nbytes] = data_byte_o;
            nbytes++;
        end
        prev_cs = flash_cs_n_o; prev_sclk = flash_sclk_o; prev_mosi = flash_mosi_o;
    end

    task automatic check_idle(input string req);
        chk(flash_cs_n_o === 1'b1 && flash_sclk_oe_o === 1'b0 && flash_mosi_oe_o === 1'b0 &&
            flash_cs_oe_o === 1'b0 && done_pull_low_o === 1'b0 && flash_sclk_o === 1'b0 &&
            data_valid_o === 1'b0, req,
            {flash_cs_n_o, flash_sclk_oe_o, flash_mosi_oe_o, flash_cs_oe_o, done_pull_low_o,
             flash_sclk_o, data_valid_o}, 7'b1000000);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_release();
        for (int i = 0; i < 4000 && flash_cs_n_o !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic run_read(input int p, input bit poke_busy);
        flash_img = PATS[p];
        pulse_start();
        chk(flash_cs_n_o === 1'b0 && flash_cs_oe_o && flash_sclk_oe_o && flash_mosi_oe_o &&
            done_pull_low_o && !flash_sclk_o, "R2 select", {flash_cs_n_o, done_pull_low_o}, 2'b01);
        if (poke_busy) begin
            repeat (100) @(negedge clk);
            pulse_start(); // R9 start while busy
        end
        wait_release();
        @(negedge clk);
        chk(first_rise == CLK_DIV/2, "R3 first rise", first_rise, CLK_DIV/2);
        chk(gap_err == 0, "R3 period", gap_err, 0);
        chk(mosi_err == 0, "R4 mosi change", mosi_err, 0);
        chk(cmd_cap == 32'h0300_0000, "R5 command", cmd_cap, 32'h0300_0000);
        chk(nbytes == NBYTES, poke_busy ? "R9 byte count" : "R7 byte count", nbytes, NBYTES);
        for (int j = 0; j < NBYTES; j++)
            chk(got[j] == PATS[p][31-8*j -: 8], "R6 R7 byte value", got[j], PATS[p][31-8*j -: 8]);
        chk(falls == 32 + CFG_BITS, poke_busy ? "R9 edge count" : "R8 edge count", falls, 32 + CFG_BITS);
        chk(valid_at_release == 1, "R8 last byte with release", valid_at_release, 1);
        check_idle("R8 released");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");
        for (int p = 0; p < NPAT; p++) run_read(p, p == 2);
        // R10: reset in mid read
        flash_img = PATS[3];
        pulse_start();
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R10 reset mid read");
        rst = 1'b0;
        @(negedge clk);
        run_read(0, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule